// File: doc/BRIEF.md
# Half-Bridge Channel Power Sequencer

This block sequences the power-up and power-down of a single half-bridge output channel in a switching audio power stage. It tells the downstream gate logic whether the output is held high-impedance, is ramping its bias, or may follow the incoming PWM stream. It also reports a ramp level code, where 0 means the output sits at ground and the all-ones value means it has reached the mid-supply bias point.

The channel is released by an active-low channel reset. The enable for soft ramping comes from a strap, and a mode code may veto it. When ramping applies, start-up waits for the PWM input to toggle and then raises the level one step at a time, and switching begins only at full bias. Pulling the channel reset low lowers the level back to ground before the output floats. When ramping does not apply, start-up instead counts a fixed number of PWM input cycles, and shutdown is immediate. A ramp in progress can reverse direction at any point, starting from the level it has reached.

Top module: `hbs_seq`

## Requirements
- R1: While the channel reset is low and no ramp-down is in progress, the status is OFF (0), the drive state is high-impedance (0) and the ramp level is 0. PWM activity has no effect in this state.
- R2: Ramp permission is captured only while the status is OFF and the channel reset is low. Changes to the ramp strap or the mode code while the channel reset is high have no effect until the next reset.
- R3: When ramping does not apply, releasing the channel reset moves the status to WAIT (2) with the drive held high-impedance. The status moves to RUN (3) with drive state switching (2) on the 35th PWM rising edge seen in WAIT, and not before that edge.
- R4: When ramping applies, the status stays OFF after the channel reset is released until a PWM rising edge is seen. The status then becomes RAMP_UP (1) with drive state ramping (1).
- R5: During RAMP_UP the level rises by exactly one every RAMP_DIV clocks. RUN is entered on the same clock that the level reaches its maximum, and never earlier.
- R6: When ramping applies, a low channel reset in RUN or RAMP_UP gives RAMP_DOWN (4). In RAMP_DOWN the level falls by one every RAMP_DIV clocks, and the status returns to OFF with high-impedance drive when the level reaches 0.
- R7: When ramping does not apply, a low channel reset moves the status from WAIT or RUN to OFF on the next clock.
- R8: A ramp reverses direction without finishing. RAMP_UP goes to RAMP_DOWN when the reset drops, and RAMP_DOWN goes back to RAMP_UP when the reset rises. The level carries on from its present value.
- R9: Mode codes 0 to 3 allow ramping. Mode codes 4 to 7 ignore the ramp strap, and the channel starts up by counting PWM cycles.
- R10: The drive state is 0 in OFF and WAIT, 1 in RAMP_UP and RAMP_DOWN, and 2 in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| chan_rst_n | input | 1 | Channel reset, active low, synchronous to clk |
| ramp_en | input | 1 | Soft-ramp strap |
| mode | input | 3 | Output mode code |
| pwm_in | input | 1 | Incoming PWM stream, asynchronous |
| drive_state | output | 2 | 0 high-impedance, 1 ramping, 2 switching |
| ramp_level | output | LVL_W | Bias level code, 0 is ground |
| seq_state | output | 3 | 0 OFF, 1 RAMP_UP, 2 WAIT, 3 RUN, 4 RAMP_DOWN |

## Verification
The assertions check the following on every clock:
- the level changes by at most one step;
- OFF always carries level 0;
- the drive never switches in the cycle after the reset is seen low;
- the captured ramp permission stays fixed while the reset is high;
- RUN is entered only from a full ramp or from the last counted PWM edge;
- RAMP_UP is entered only from a detected PWM edge.

Only the bench scenarios can show the exact number of clocks per ramp step, that 34 PWM cycles are not enough, that the level carries over at a reversal, and that the reserved modes override the strap.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    SEQ_OFF       = 3'd0,
    SEQ_RAMP_UP   = 3'd1,
    SEQ_WAIT      = 3'd2,
    SEQ_RUN       = 3'd3,
    SEQ_RAMP_DOWN = 3'd4
  } seq_e;

  typedef enum logic [1:0] {
    DRV_HIZ    = 2'd0,
    DRV_RAMP   = 2'd1,
    DRV_SWITCH = 2'd2
  } drv_e;

  // Drive state seen by the gate logic for each sequencer state
  function automatic drv_e drv_of(seq_e s);
    case (s)
      SEQ_RAMP_UP, SEQ_RAMP_DOWN: return DRV_RAMP;
      SEQ_RUN:                    return DRV_SWITCH;
      default:                    return DRV_HIZ;
    endcase
  endfunction

  // Codes with the top bit set do not allow ramping
  function automatic logic ramp_permitted(logic [MODE_W-1:0] m, logic en);
    return en && !m[MODE_W-1];
  endfunction

endpackage

// File: rtl/hbs_pwm_edge.sv
module hbs_pwm_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  output logic pwm_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= pwm_in;
        else sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else last_q <= sync_q[SYNC_STAGES-1];
  end

  assign pwm_rise = sync_q[SYNC_STAGES-1] && !last_q;
endmodule

// File: rtl/hbs_cycle_count.sv
module hbs_cycle_count #(
  parameter int TARGET = 35,
  localparam int CNT_W = $clog2(TARGET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TARGET - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(TARGET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST);
endmodule

// File: rtl/hbs_ramp_gen.sv
module hbs_ramp_gen #(
  parameter int LVL_W    = 4,
  parameter int RAMP_DIV = 4,
  localparam int DIV_W   = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             restart,
  input  logic             go_up,
  input  logic             go_dn,
  output logic [LVL_W-1:0] level,
  output logic             step
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RAMP_DIV - 1);
  localparam logic [LVL_W-1:0] LVL_MAX  = '1;

  logic [DIV_W-1:0] div_q;
  logic             moving;

  assign moving = go_up || go_dn;
  assign step   = moving && (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (clear || restart || !moving || step) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else if (clear) level <= '0;
    else if (step && go_up && level != LVL_MAX) level <= level + 1'b1;
    else if (step && go_dn && level != '0) level <= level - 1'b1;
  end
endmodule

// File: rtl/hbs_seq.sv
module hbs_seq
  import hbs_pkg::*;
#(
  parameter int LVL_W       = 4,
  parameter int RAMP_DIV    = 4,
  parameter int CYC_COUNT   = 35,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(CYC_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst_n,
  input  logic              ramp_en,
  input  logic [2:0]        mode,
  input  logic              pwm_in,
  output logic [1:0]        drive_state,
  output logic [LVL_W-1:0]  ramp_level,
  output logic [2:0]        seq_state
);
  localparam logic [LVL_W-1:0] LVL_MAX  = '1;
  localparam logic [LVL_W-1:0] LVL_NEAR = LVL_MAX - 1'b1;
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);

  seq_e             state_q, state_d;
  logic             cfg_ramp_q;
  logic             pwm_rise;
  logic [CNT_W-1:0] cyc_cnt;
  logic             cyc_last;
  logic             ramp_step;
  logic [LVL_W-1:0] level;

  hbs_pwm_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_rise(pwm_rise)
  );

  hbs_cycle_count #(.TARGET(CYC_COUNT)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clear(state_q != SEQ_WAIT), .inc(pwm_rise),
    .cnt(cyc_cnt), .at_last(cyc_last)
  );

  hbs_ramp_gen #(.LVL_W(LVL_W), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q == SEQ_OFF), .restart(state_d != state_q),
    .go_up(state_q == SEQ_RAMP_UP), .go_dn(state_q == SEQ_RAMP_DOWN),
    .level(level), .step(ramp_step)
  );

  // Ramp permission is captured only in OFF while the channel is held in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_ramp_q <= 1'b0;
    else if (state_q == SEQ_OFF && !chan_rst_n) cfg_ramp_q <= ramp_permitted(mode, ramp_en);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_OFF: begin
        if (chan_rst_n) begin
          if (!cfg_ramp_q) state_d = SEQ_WAIT;
          else if (pwm_rise) state_d = SEQ_RAMP_UP;
        end
      end
      SEQ_WAIT: begin
        if (!chan_rst_n) state_d = SEQ_OFF;
        else if (pwm_rise && cyc_last) state_d = SEQ_RUN;
      end
      SEQ_RAMP_UP: begin
        if (!chan_rst_n) state_d = SEQ_RAMP_DOWN;
        else if (ramp_step && level == LVL_NEAR) state_d = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (!chan_rst_n) state_d = cfg_ramp_q ? SEQ_RAMP_DOWN : SEQ_OFF;
      end
      SEQ_RAMP_DOWN: begin
        if (chan_rst_n) state_d = (level == LVL_MAX) ? SEQ_RUN : SEQ_RAMP_UP;
        else if (level == '0 || (ramp_step && level == LVL_ONE)) state_d = SEQ_OFF;
      end
      default: state_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_OFF;
    else state_q <= state_d;
  end

  assign seq_state   = state_q;
  assign drive_state = drv_of(state_q);
  assign ramp_level  = level;
endmodule

// File: rtl/hbs_seq_chk.sv
module hbs_seq_chk #(
  parameter int LVL_W     = 4,
  parameter int CYC_COUNT = 35,
  localparam int CNT_W    = $clog2(CYC_COUNT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_rst_n,
  input logic [1:0]       drive_state,
  input logic [LVL_W-1:0] ramp_level,
  input logic [2:0]       seq_state,
  input logic             cfg_ramp,
  input logic             pwm_rise,
  input logic [CNT_W-1:0] cyc_cnt
);
  localparam logic [LVL_W:0]   ONE_X   = (LVL_W+1)'(1);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(CYC_COUNT - 1);

  p_off_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 3'd0 |-> ramp_level == '0);

  p_no_switch_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!chan_rst_n) |-> drive_state != 2'd2);

  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst_n |=> $stable(cfg_ramp));

  p_wait_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd3 && $past(seq_state) == 3'd2) |-> $past(cyc_cnt) == LAST);

  p_ramp_needs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd1 && $past(seq_state) == 3'd0) |-> $past(pwm_rise));

  p_level_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_level != $past(ramp_level) |->
      ({1'b0, ramp_level} == {1'b0, $past(ramp_level)} + ONE_X) ||
      ({1'b0, ramp_level} + ONE_X == {1'b0, $past(ramp_level)}));

  p_run_at_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd3 && $past(seq_state) == 3'd1) |-> ramp_level == LVL_MAX);

  p_fast_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ramp && !chan_rst_n) |=> seq_state == 3'd0);

  p_ramp_only_permitted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd1 || seq_state == 3'd4) |-> cfg_ramp);
endmodule

bind hbs_seq hbs_seq_chk #(.LVL_W(LVL_W), .CYC_COUNT(CYC_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_rst_n(chan_rst_n),
  .drive_state(drive_state), .ramp_level(ramp_level), .seq_state(seq_state),
  .cfg_ramp(cfg_ramp_q), .pwm_rise(pwm_rise), .cyc_cnt(cyc_cnt)
);

// File: tb/hbs_seq_tb.sv
module hbs_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int TOPL = 15;

  logic       clk = 1'b0;
  logic       rst_n, chan_rst_n, ramp_en, pwm_in;
  logic [2:0] mode;
  logic [1:0] drive_state;
  logic [3:0] ramp_level;
  logic [2:0] seq_state;

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbs_seq dut_i (
    .clk(clk), .rst_n(rst_n), .chan_rst_n(chan_rst_n), .ramp_en(ramp_en),
    .mode(mode), .pwm_in(pwm_in), .drive_state(drive_state),
    .ramp_level(ramp_level), .seq_state(seq_state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
        finish_run();
      end
    end
  end

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      pwm_in = 1'b1; repeat (4) @(negedge clk);
      pwm_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic latch_cfg(input logic [2:0] m, input logic en);
    chan_rst_n = 1'b0; mode = m; ramp_en = en;
    repeat (3) @(negedge clk);
    chan_rst_n = 1'b1;
  endtask

  task automatic wait_state(input int s, input int limit);
    for (int k = 0; k < limit && seq_state != 3'(s); k++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chan_rst_n = 1'b0; ramp_en = 1'b0; mode = 3'd0; pwm_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "status after reset", seq_state, 0);
    chk("R1", "drive after reset", drive_state, 0);
    chk("R1", "level after reset", ramp_level, 0);
    ramp_en = 1'b1;
    pulses(3);
    chk("R1", "status with pwm in reset", seq_state, 0);
    chk("R10", "drive OFF", drive_state, 0);
  endtask

  task automatic t_nonramp();
    latch_cfg(3'd0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R3", "status WAIT", seq_state, 2);
    chk("R10", "drive in WAIT", drive_state, 0);
    pulses(34);
    repeat (6) @(negedge clk);
    chk("R3", "still WAIT after 34", seq_state, 2);
    pulses(1);
    repeat (6) @(negedge clk);
    chk("R3", "RUN after 35", seq_state, 3);
    chk("R10", "drive switching", drive_state, 2);
    chan_rst_n = 1'b0;
    @(negedge clk);
    chk("R7", "OFF one clock after reset", seq_state, 0);
    chk("R7", "drive hiz", drive_state, 0);
  endtask

  task automatic t_ramp();
    int i, bad;
    latch_cfg(3'd0, 1'b1);
    repeat (20) @(negedge clk);
    chk("R4", "OFF without pwm edge", seq_state, 0);
    pwm_in = 1'b1;
    wait_state(1, 20);
    pwm_in = 1'b0;
    chk("R4", "RAMP_UP after edge", seq_state, 1);
    chk("R10", "drive ramping", drive_state, 1);
    i = 0; bad = 0;
    while (seq_state == 3'd1 && i < 200) begin
      if (ramp_level != 4'(i / DIV)) bad++;
      i++;
      @(negedge clk);
    end
    chk("R5", "level trace errors up", bad, 0);
    chk("R5", "clocks in RAMP_UP", i, TOPL * DIV);
    chk("R5", "RUN at top", seq_state, 3);
    chk("R5", "level at top", ramp_level, TOPL);
    chan_rst_n = 1'b0;
    @(negedge clk);
    chk("R6", "RAMP_DOWN entered", seq_state, 4);
    i = 0; bad = 0;
    while (seq_state == 3'd4 && i < 200) begin
      if (ramp_level != 4'(TOPL - i / DIV)) bad++;
      if (drive_state != 2'd1) bad++;
      i++;
      @(negedge clk);
    end
    chk("R6", "level trace errors down", bad, 0);
    chk("R6", "clocks in RAMP_DOWN", i, TOPL * DIV);
    chk("R6", "OFF at ground", seq_state, 0);
    chk("R6", "level zero", ramp_level, 0);
    chk("R6", "drive hiz", drive_state, 0);
  endtask

  task automatic t_reverse();
    int k;
    latch_cfg(3'd2, 1'b1);
    @(negedge clk);
    pwm_in = 1'b1;
    wait_state(1, 20);
    pwm_in = 1'b0;
    repeat (26) @(negedge clk);
    chk("R5", "level mid ramp", ramp_level, 6);
    chan_rst_n = 1'b0;
    @(negedge clk);
    chk("R8", "reverse to down", seq_state, 4);
    chk("R8", "level kept at reversal", ramp_level, 6);
    repeat (8) @(negedge clk);
    chk("R8", "level after two steps down", ramp_level, 4);
    chan_rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reverse to up", seq_state, 1);
    chk("R8", "level kept at second reversal", ramp_level, 4);
    k = 0;
    while (seq_state == 3'd1 && k < 200) begin k++; @(negedge clk); end
    chk("R8", "clocks to finish ramp", k, (TOPL - 4) * DIV);
    chk("R8", "RUN after resumed ramp", seq_state, 3);
    chan_rst_n = 1'b0;
    wait_state(0, 100);
    chk("R6", "back to OFF", seq_state, 0);
  endtask

  task automatic t_reserved();
    latch_cfg(3'd5, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9", "reserved mode counts cycles", seq_state, 2);
    pulses(35);
    repeat (6) @(negedge clk);
    chk("R9", "RUN without ramp", seq_state, 3);
    chk("R9", "level stays zero", ramp_level, 0);
    chan_rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "immediate OFF", seq_state, 0);
  endtask

  task automatic t_cfg_freeze();
    latch_cfg(3'd0, 1'b0);
    repeat (3) @(negedge clk);
    ramp_en = 1'b1;
    pulses(35);
    repeat (6) @(negedge clk);
    chk("R2", "strap change ignored, RUN", seq_state, 3);
    chk("R2", "level zero", ramp_level, 0);
    chan_rst_n = 1'b0;
    @(negedge clk);
    chk("R2", "non-ramp shutdown kept", seq_state, 0);
  endtask

  initial begin
    t_reset();
    t_nonramp();
    t_ramp();
    t_reverse();
    t_reserved();
    t_cfg_freeze();
    finish_run();
  end
endmodule